// File: doc/BRIEF.md
# Switch Table Access Command Engine

This block gives a host processor register access to the switch's internal configuration tables. The host fills one or two data registers and then writes a command word that names a table, an entry index and a direction. The engine then reads or writes that entry in its own on-chip memory. On a read it loads the data registers from the entry. A busy flag in the command word reads as 1 until the access is done, so the host polls it before using the data.

Two engine instances sit behind one small register window. The main engine holds the per-VLAN membership and attribute table and the per-spanning-tree-instance port state table. The second engine holds the per-VLAN untagged member mask. Each table has its own data-word packing. Table types that an engine does not hold, and indices beyond a table's depth, are treated as absent entries.

Top module: `swtab_access`

## Requirements
- R1: After reset every command and data register reads as zero and both engines are idle.
- R2: Command word layout: bit 15 execute, bit 14 direction (1 = read, 0 = write), bits 13:12 table type, bits 11:0 entry index. Reading the command word returns bits 14:0 as last accepted, bit 15 as the busy flag and zero in bits 31:16.
- R3: A command write with bit 15 set starts an access, and the busy flag reads as 1 for exactly the two clock cycles after that write. A command write with bit 15 clear stores bits 14:0 and starts nothing.
- R4: While an engine is busy, host writes to any of its registers are ignored.
- R5: Main engine, type 00 (VLAN): data word 0 is the 32-bit tagged member mask. In data word 1, bits 2:0 hold the profile, bit 3 the multicast filter-ID hash enable, bit 4 the unicast hash enable and bits 10:5 the 6-bit filter ID. Bits 31:11 are not stored and read back as zero.
- R6: Main engine, type 10 (spanning-tree instance): the entry stores all 64 bits of data words 0 and 1.
- R7: The untagged engine holds type 00 only. Its entry is the 29-bit mask in data word 0 bits 28:0, and bits 31:29 read back as zero. Its table is separate from the main engine's tables, and the main engine's two tables are separate from each other.
- R8: A read loads the data registers from the entry by the time busy clears. A write stores the data registers as they stood when execute was written.
- R9: An unsupported table type (01 or 11 on the main engine, anything but 00 on the untagged engine) reads as zero in every data word and, on a write, changes no entry.
- R10: An index at or above the table depth (VLAN_AW or STP_AW address bits) reads as zero and, on a write, changes no entry. Entries below the depth do not alias it.
- R11: Register window on host_addr: 0 main command, 1 main data 0, 2 main data 1, 4 untagged command, 5 untagged data 0. Other addresses read zero and ignore writes. host_rdata updates on the clock edge where host_re is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |

## Verification
The case that is hardest to reach is host traffic landing inside the two-cycle busy window. Normal use always polls busy before touching the engine, so such writes never happen that way. The stimulus issues a command and then, with no gap, a data write and a second command on the next two edges. It then reads back the data register, the command fields and the table entry to show that none of them was disturbed. Aliasing of out-of-range indices is reached the same way: an entry below the table depth is written, a write is aimed at an index just past the depth, and the low entry is read back.

// File: rtl/tac_pkg.sv
package tac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FIN  = 2'd2
  } tac_state_t;

  localparam logic [1:0] TT_VLAN = 2'b00;
  localparam logic [1:0] TT_STP  = 2'b10;

  localparam int VLAN_ATTR_W = 11;
  localparam int UNTAG_W     = 29;
  localparam int IDX_W       = 12;

  localparam logic [1:0] SEL_CMD = 2'd0;
  localparam logic [1:0] SEL_D0  = 2'd1;
  localparam logic [1:0] SEL_D1  = 2'd2;
endpackage

// File: rtl/tac_ram.sv
module tac_ram #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rq
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rq <= mem[addr];
  end
endmodule

// File: rtl/tac_engine.sv
module tac_engine
  import tac_pkg::*;
#(
  parameter bit MAIN    = 1'b1,
  parameter int VLAN_AW = 8,
  parameter int STP_AW  = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [1:0]  wsel,
  input  logic [31:0] wdata,
  output logic [31:0] cmd_o,
  output logic [31:0] d0_o,
  output logic [31:0] d1_o
);
  localparam int VLAN_DEPTH = 1 << VLAN_AW;
  localparam int STP_DEPTH  = 1 << STP_AW;
  localparam int VLAN_W     = 32 + VLAN_ATTR_W;
  localparam int STP_W      = 64;

  tac_state_t       st;
  logic             dir;
  logic [1:0]       tt;
  logic [IDX_W-1:0] idx;
  logic [31:0]      d0, d1;
  logic             hit_q;
  logic             busy;
  logic             acc;
  logic             vlan_ok, stp_ok, hit;
  logic [31:0]      rd0, rd1;

  assign busy = (st != ST_IDLE);
  assign acc  = (st == ST_ACC);

  assign vlan_ok = ({1'b0, idx} < (IDX_W+1)'(VLAN_DEPTH));
  assign stp_ok  = ({1'b0, idx} < (IDX_W+1)'(STP_DEPTH));

  generate
    if (MAIN) begin : g_main
      logic [VLAN_W-1:0] vlan_q;
      logic [STP_W-1:0]  stp_q;
      logic              vlan_sel, stp_sel;

      assign vlan_sel = (tt == TT_VLAN) && vlan_ok;
      assign stp_sel  = (tt == TT_STP) && stp_ok;
      assign hit      = vlan_sel || stp_sel;

      tac_ram #(.W(VLAN_W), .AW(VLAN_AW)) u_vlan (
        .clk  (clk),
        .we   (acc && !dir && vlan_sel),
        .re   (acc && dir && vlan_sel),
        .addr (idx[VLAN_AW-1:0]),
        .wd   ({d1[VLAN_ATTR_W-1:0], d0}),
        .rq   (vlan_q)
      );

      tac_ram #(.W(STP_W), .AW(STP_AW)) u_stp (
        .clk  (clk),
        .we   (acc && !dir && stp_sel),
        .re   (acc && dir && stp_sel),
        .addr (idx[STP_AW-1:0]),
        .wd   ({d1, d0}),
        .rq   (stp_q)
      );

      always_comb begin
        if (tt == TT_STP) begin
          rd0 = stp_q[31:0];
          rd1 = stp_q[63:32];
        end else begin
          rd0 = vlan_q[31:0];
          rd1 = {{(32-VLAN_ATTR_W){1'b0}}, vlan_q[VLAN_W-1:32]};
        end
      end
    end else begin : g_untag
      logic [UNTAG_W-1:0] ut_q;
      logic               ut_sel;

      assign ut_sel = (tt == TT_VLAN) && vlan_ok;
      assign hit    = ut_sel;

      tac_ram #(.W(UNTAG_W), .AW(VLAN_AW)) u_untag (
        .clk  (clk),
        .we   (acc && !dir && ut_sel),
        .re   (acc && dir && ut_sel),
        .addr (idx[VLAN_AW-1:0]),
        .wd   (d0[UNTAG_W-1:0]),
        .rq   (ut_q)
      );

      assign rd0 = {{(32-UNTAG_W){1'b0}}, ut_q};
      assign rd1 = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      dir   <= 1'b0;
      tt    <= '0;
      idx   <= '0;
      d0    <= '0;
      d1    <= '0;
      hit_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (we) begin
            case (wsel)
              SEL_CMD: begin
                dir <= wdata[14];
                tt  <= wdata[13:12];
                idx <= wdata[IDX_W-1:0];
                if (wdata[15]) st <= ST_ACC;
              end
              SEL_D0: d0 <= wdata;
              SEL_D1: if (MAIN) d1 <= wdata;
              default: ;
            endcase
          end
        end
        ST_ACC: begin
          hit_q <= hit;
          st    <= ST_FIN;
        end
        ST_FIN: begin
          if (dir) begin
            d0 <= hit_q ? rd0 : '0;
            d1 <= hit_q ? rd1 : '0;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o = {16'b0, busy, dir, tt, idx};
  assign d0_o  = d0;
  assign d1_o  = d1;

  // R3
  busy_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && we && wsel == SEL_CMD && wdata[15]) |=> (busy ##1 busy ##1 !busy));

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(dir) && $stable(tt) && $stable(idx)));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> ($stable(d0) && $stable(d1)));

  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIN && dir && !hit_q) |=> (d0 == 32'd0 && d1 == 32'd0));
endmodule

// File: rtl/swtab_access.sv
module swtab_access
  import tac_pkg::*;
#(
  parameter int VLAN_AW = 8,
  parameter int STP_AW  = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_we,
  input  logic        host_re,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam int N_ENG = 2;

  logic [31:0] cmd_w [N_ENG];
  logic [31:0] d0_w  [N_ENG];
  logic [31:0] d1_w  [N_ENG];
  logic        eng_we [N_ENG];

  assign eng_we[0] = host_we && !host_addr[2] && (host_addr[1:0] != 2'd3);
  assign eng_we[1] = host_we && host_addr[2] && (host_addr[1:0] < 2'd2);

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    tac_engine #(
      .MAIN    (g == 0),
      .VLAN_AW (VLAN_AW),
      .STP_AW  (STP_AW)
    ) u_eng (
      .clk   (clk),
      .rst   (rst),
      .we    (eng_we[g]),
      .wsel  (host_addr[1:0]),
      .wdata (host_wdata),
      .cmd_o (cmd_w[g]),
      .d0_o  (d0_w[g]),
      .d1_o  (d1_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_re) begin
      case (host_addr)
        3'd0:    host_rdata <= cmd_w[0];
        3'd1:    host_rdata <= d0_w[0];
        3'd2:    host_rdata <= d1_w[0];
        3'd4:    host_rdata <= cmd_w[1];
        3'd5:    host_rdata <= d0_w[1];
        default: host_rdata <= '0;
      endcase
    end
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_re |=> $stable(host_rdata));
endmodule

// File: tb/swtab_access_test.sv
`timescale 1ns/1ps
module swtab_access_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_we, host_re;
  logic [2:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  swtab_access uut (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  typedef struct packed {
    logic        eng;
    logic [1:0]  tt;
    logic [11:0] idx;
    logic [31:0] d0;
    logic [31:0] d1;
    logic [31:0] e0;
    logic [31:0] e1;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b00, 12'd5,   32'hDEADBEEF, 32'hFFFFFFFF, 32'hDEADBEEF, 32'h000007FF},
    '{1'b0, 2'b00, 12'd255, 32'h00000001, 32'h00000123, 32'h00000001, 32'h00000123},
    '{1'b0, 2'b10, 12'd7,   32'h12345678, 32'h9ABCDEF0, 32'h12345678, 32'h9ABCDEF0},
    '{1'b0, 2'b10, 12'd63,  32'hAAAAAAAA, 32'h55555555, 32'hAAAAAAAA, 32'h55555555},
    '{1'b1, 2'b00, 12'd5,   32'hFFFFFFFF, 32'h00000000, 32'h1FFFFFFF, 32'h00000000},
    '{1'b1, 2'b00, 12'd200, 32'h10000002, 32'h00000000, 32'h10000002, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic run_cmd(input logic eng, input logic [31:0] cmd);
    wr(eng ? 3'd4 : 3'd0, cmd);
    repeat (3) @(negedge clk);
  endtask

  task automatic load(input logic eng, input logic [31:0] a, input logic [31:0] b);
    wr(eng ? 3'd5 : 3'd1, a);
    if (!eng) wr(3'd2, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    host_we = 0; host_re = 0; host_addr = 0; host_wdata = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    rd(3'd0, v); chk("R1 main cmd", v, 32'h0);
    rd(3'd1, v); chk("R1 main d0", v, 32'h0);
    rd(3'd2, v); chk("R1 main d1", v, 32'h0);
    rd(3'd4, v); chk("R1 untag cmd", v, 32'h0);
    rd(3'd5, v); chk("R1 untag d0", v, 32'h0);

    // R5 R6 R7 R8: vector table, write then read back
    for (int i = 0; i < NV; i++) begin
      load(VEC[i].eng, VEC[i].d0, VEC[i].d1);
      run_cmd(VEC[i].eng, 32'h8000 | (32'(VEC[i].tt) << 12) | 32'(VEC[i].idx));
      load(VEC[i].eng, 32'h0, 32'h0);
      run_cmd(VEC[i].eng, 32'hC000 | (32'(VEC[i].tt) << 12) | 32'(VEC[i].idx));
      rd(VEC[i].eng ? 3'd5 : 3'd1, v); chk("R8 vector d0 (R5/R6/R7)", v, VEC[i].e0);
      if (!VEC[i].eng) begin
        rd(3'd2, v); chk("R8 vector d1 (R5/R6)", v, VEC[i].e1);
      end
    end

    // R3: busy for exactly two cycles after a command
    wr(3'd0, 32'hC007);
    rd(3'd0, v); chk("R3 busy cycle 1", v, 32'h0000C007);
    rd(3'd0, v); chk("R3 busy cycle 2", v, 32'h0000C007);
    rd(3'd0, v); chk("R3 idle cycle 3 (R2)", v, 32'h00004007);

    // R3: execute clear stores fields only
    wr(3'd1, 32'h0BADF00D);
    wr(3'd0, 32'h4005);
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R3 no-exec cmd", v, 32'h00004005);
    rd(3'd1, v); chk("R3 no-exec data kept", v, 32'h0BADF00D);

    // R4: writes during busy ignored
    wr(3'd1, 32'h11111111);
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h8009);
    wr(3'd1, 32'h22222222);
    wr(3'd0, 32'hA003);
    repeat (3) @(negedge clk);
    rd(3'd1, v); chk("R4 data write ignored", v, 32'h11111111);
    rd(3'd0, v); chk("R4 cmd write ignored", v, 32'h00000009);
    load(1'b0, 32'h0, 32'h0);
    run_cmd(1'b0, 32'hC009);
    rd(3'd1, v); chk("R4 entry from first cmd", v, 32'h11111111);

    // R9: unsupported types
    load(1'b0, 32'h0, 32'h0);
    run_cmd(1'b0, 32'h9005);
    run_cmd(1'b0, 32'hC005);
    rd(3'd1, v); chk("R9 type01 write ignored", v, 32'hDEADBEEF);
    load(1'b0, 32'h5555, 32'h6666);
    run_cmd(1'b0, 32'hF005);
    rd(3'd1, v); chk("R9 type11 read d0", v, 32'h0);
    rd(3'd2, v); chk("R9 type11 read d1", v, 32'h0);
    load(1'b1, 32'h7777, 32'h0);
    run_cmd(1'b1, 32'hE005);
    rd(3'd5, v); chk("R9 untag type10 read", v, 32'h0);
    load(1'b1, 32'h0, 32'h0);
    run_cmd(1'b1, 32'hA005);
    run_cmd(1'b1, 32'hC005);
    rd(3'd5, v); chk("R9 untag type10 write ignored", v, 32'h1FFFFFFF);

    // R7: tables separate (STP 5 vs VLAN 5)
    load(1'b0, 32'h0F0F0F0F, 32'hF0F0F0F0);
    run_cmd(1'b0, 32'hA005);
    run_cmd(1'b0, 32'hC005);
    rd(3'd1, v); chk("R7 vlan5 after stp5 write", v, 32'hDEADBEEF);
    run_cmd(1'b0, 32'hE005);
    rd(3'd2, v); chk("R7 stp5 d1", v, 32'hF0F0F0F0);

    // R10: index past depth
    load(1'b0, 32'hCAFE0000, 32'h0);
    run_cmd(1'b0, 32'h8000);
    load(1'b0, 32'h00000BAD, 32'h0);
    run_cmd(1'b0, 32'h8100);
    run_cmd(1'b0, 32'hC000);
    rd(3'd1, v); chk("R10 no alias onto idx0", v, 32'hCAFE0000);
    run_cmd(1'b0, 32'hC100);
    rd(3'd1, v); chk("R10 read past depth", v, 32'h0);
    load(1'b0, 32'h1234, 32'h0);
    run_cmd(1'b0, 32'hE040);
    rd(3'd1, v); chk("R10 stp read past depth", v, 32'h0);

    // R11: unmapped addresses
    wr(3'd6, 32'hFFFFFFFF);
    rd(3'd3, v); chk("R11 addr3 reads zero", v, 32'h0);
    rd(3'd7, v); chk("R11 addr7 reads zero", v, 32'h0);
    rd(3'd5, v); chk("R11 addr6 write ignored", v, 32'h1FFFFFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule